// File: doc/BRIEF.md
# Serial Debug Instruction Executor

This block sits behind a byte-wide serial physical layer of a debug port. Every received byte is taken either as an instruction or, when a store is pending, as that store's data. Five instruction patterns are recognised. They move bytes between the physical layer and three targets: a 16-bit pointer register, a 64-location I/O space reached through an external strobe-based port, and an internal bank of 16 control/status locations.

Store instructions take two bytes: the instruction, then one data byte. Load instructions produce one byte, which is offered to the physical layer with a request/acknowledge handshake. The executor takes no new instruction until the physical layer acknowledges that byte. The pointer register is brought out on its own port so that neighbouring logic can use it.

Top module: `dbg_exec`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the block is in this state: tx_req, io_rd and io_wr are low, ptr_value is 0x0000 and every control/status location reads 0x00.
- R2: Byte 0110100s followed by data byte D writes D into pointer byte s. s=0 selects bits 7:0 and s=1 selects bits 15:8. The new value shows on ptr_value in the cycle after the edge that samples D.
- R3: Byte 0hh1llll is an I/O read of address {hh,llll}. In the cycle after the edge that samples it, io_rd is high for exactly one cycle, with that address on io_addr. io_rd and io_wr are never high together.
- R4: For an I/O read, io_rdata is sampled in the cycle after the io_rd cycle. tx_req rises two cycles after io_rd, carrying that byte on tx_byte. tx_req and tx_byte hold until tx_ack is seen high at a clock edge.
- R5: Byte 1hh1llll followed by data byte D raises io_wr for exactly one cycle, in the cycle after the edge that samples D. During that cycle io_addr is {hh,llll} and io_wdata is D.
- R6: Byte 1000cccc raises tx_req in the next cycle, carrying control/status location cccc on tx_byte.
- R7: Byte 1100cccc followed by data byte D writes D into control/status location cccc.
- R8: Only the locations whose bit is set in CSR_IMPL_MASK (default 16'h00F3: locations 0, 1, 4, 5, 6, 7) exist. Writes to the other locations are discarded, and reads from them return 0x00.
- R9: Once a store instruction has been accepted, the next received byte is always taken as data, even if it matches an instruction pattern.
- R10: Bytes that arrive while a read is in progress or a load result is waiting for tx_ack are dropped and have no effect.
- R11: Any byte matching none of the five patterns (for example 0x6A, 0x6C, 0x00, 0xA0 and 0xE5) is ignored: it starts no strobe, no transmission and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| tx_req | output | 1 | A load result waits for transmission |
| tx_byte | output | 8 | Byte to transmit |
| tx_ack | input | 1 | Physical layer has finished sending tx_byte |
| io_rd | output | 1 | One-cycle I/O read strobe |
| io_wr | output | 1 | One-cycle I/O write strobe |
| io_addr | output | 6 | I/O address, valid during a strobe |
| io_wdata | output | 8 | I/O write data, valid with io_wr |
| io_rdata | input | 8 | I/O read data, returned in the cycle after io_rd |
| ptr_value | output | 16 | Current pointer register |

## Verification
The bench holds a reference model that advances on every clock edge. One time unit after the edge, the model's expected strobes, address, data, transmit request and pointer are compared with the outputs, so each result is checked in its exact cycle. Each result is due as follows:
- A control/status load appears one cycle after its instruction byte.
- An I/O read strobe comes one cycle after its instruction byte, and its transmit request two cycles after the strobe.
- An I/O write strobe and a pointer update come one cycle after the data byte.

Directed checks at falling edges confirm the values of control/status and I/O bytes read back, and cover dropped, ignored and mistaken-for-instruction bytes.

// File: rtl/dbg_exec_pkg.sv
// Package: types and fixed widths shared by the debug instruction executor.
// Assumes byte-wide data; the address widths follow from the opcode layout.
package dbg_exec_pkg;
    localparam int DW        = 8;
    localparam int IO_AW     = 6;
    localparam int CS_AW     = 4;
    localparam int PTR_BYTES = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT_DATA, ST_RD_STROBE, ST_RD_CAPTURE, ST_WR_STROBE, ST_SEND
    } exec_state_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_PTR_ST, OP_IO_RD, OP_IO_WR, OP_CS_LD, OP_CS_ST
    } op_kind_t;

    typedef struct packed {
        op_kind_t         kind;
        logic [IO_AW-1:0] addr;
    } op_dec_t;
endpackage

// File: rtl/dbg_decode.sv
// Module: purely combinational instruction decoder.
// Classifies a byte into one of five kinds and gathers its scattered address bits.
// Assumes nothing about state; the caller decides whether the byte is an instruction.
module dbg_decode
    import dbg_exec_pkg::*;
(
    input  logic [DW-1:0] op,
    output op_dec_t       dec
);
    // Match the opcode patterns and extract the address field.
    always_comb begin
        dec.kind = OP_NONE;
        dec.addr = '0;
        if (op[7:1] == 7'b0110100) begin
            dec.kind = OP_PTR_ST;
            dec.addr = {5'b0, op[0]};
        end else if (!op[7] && op[4]) begin
            dec.kind = OP_IO_RD;
            dec.addr = {op[6:5], op[3:0]};
        end else if (op[7] && op[4]) begin
            dec.kind = OP_IO_WR;
            dec.addr = {op[6:5], op[3:0]};
        end else if (op[7:4] == 4'b1000) begin
            dec.kind = OP_CS_LD;
            dec.addr = {2'b0, op[3:0]};
        end else if (op[7:4] == 4'b1100) begin
            dec.kind = OP_CS_ST;
            dec.addr = {2'b0, op[3:0]};
        end
    end
endmodule

// File: rtl/dbg_ptr_reg.sv
// Module: byte-writable pointer register.
// One byte is written per cycle, selected by sel. Assumes sel < BYTES.
module dbg_ptr_reg #(
    parameter int BYTES = 2,
    localparam int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [7:0]         wdata,
    output logic [BYTES*8-1:0] value
);
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        logic [7:0] byte_q;
        // Load this byte when it is the selected one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (wr_en && sel == SEL_W'(g))
                byte_q <= wdata;
        end
        assign value[g*8 +: 8] = byte_q;
    end
endmodule

// File: rtl/dbg_csr_file.sv
// Module: sparse control/status register bank.
// Only locations whose bit is set in IMPL_MASK hold data; the other
// locations discard writes and read as zero. Read is combinational.
module dbg_csr_file #(
    parameter int DEPTH = 16,
    parameter logic [DEPTH-1:0] IMPL_MASK = 16'h00F3,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] regs [DEPTH];

    // Clear on reset; write only the implemented locations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (IMPL_MASK[i] && wr_addr == AW'(i)) regs[i] <= wdata;
        end
    end

    // Return stored data, or zero for absent locations.
    always_comb rd_data = IMPL_MASK[rd_addr] ? regs[rd_addr] : 8'h00;
endmodule

// File: rtl/dbg_exec.sv
// Module: debug instruction executor (top).
// Takes bytes from the serial physical layer, runs pointer, I/O and
// control/status transfers, and returns load results through tx_req/tx_ack.
// Assumes rx_valid is a one-cycle strobe per byte, and that the I/O target
// returns read data in the cycle after io_rd.
module dbg_exec
    import dbg_exec_pkg::*;
#(
    parameter logic [15:0] CSR_IMPL_MASK = 16'h00F3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_byte,
    output logic             tx_req,
    output logic [DW-1:0]    tx_byte,
    input  logic             tx_ack,
    output logic             io_rd,
    output logic             io_wr,
    output logic [IO_AW-1:0] io_addr,
    output logic [DW-1:0]    io_wdata,
    input  logic [DW-1:0]    io_rdata,
    output logic [PTR_BYTES*8-1:0] ptr_value
);
    localparam int CS_DEPTH = 1 << CS_AW;

    exec_state_t      state;
    op_kind_t         pend_kind;
    logic [IO_AW-1:0] pend_addr;
    logic [DW-1:0]    tx_q;
    logic [DW-1:0]    wdata_q;
    op_dec_t          dec;
    logic [DW-1:0]    cs_rd_data;
    logic             store_data;
    logic             ptr_wr_en;
    logic             cs_wr_en;

    dbg_decode u_dec (.op(rx_byte), .dec(dec));

    // A data byte for a pending store is present this cycle.
    assign store_data = (state == ST_WAIT_DATA) && rx_valid;
    assign ptr_wr_en  = store_data && (pend_kind == OP_PTR_ST);
    assign cs_wr_en   = store_data && (pend_kind == OP_CS_ST);

    dbg_ptr_reg #(.BYTES(PTR_BYTES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr_en),
        .sel(pend_addr[0]), .wdata(rx_byte), .value(ptr_value)
    );

    dbg_csr_file #(.DEPTH(CS_DEPTH), .IMPL_MASK(CSR_IMPL_MASK)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(cs_wr_en),
        .wr_addr(pend_addr[CS_AW-1:0]), .wdata(rx_byte),
        .rd_addr(dec.addr[CS_AW-1:0]), .rd_data(cs_rd_data)
    );

    // Sequence each instruction through its phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_kind <= OP_NONE;
            pend_addr <= '0;
            tx_q      <= '0;
            wdata_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (rx_valid) begin
                    unique case (dec.kind)
                        OP_PTR_ST, OP_IO_WR, OP_CS_ST: begin
                            pend_kind <= dec.kind;
                            pend_addr <= dec.addr;
                            state     <= ST_WAIT_DATA;
                        end
                        OP_IO_RD: begin
                            pend_addr <= dec.addr;
                            state     <= ST_RD_STROBE;
                        end
                        OP_CS_LD: begin
                            tx_q  <= cs_rd_data;
                            state <= ST_SEND;
                        end
                        default: ;
                    endcase
                end
                ST_WAIT_DATA: if (rx_valid) begin
                    if (pend_kind == OP_IO_WR) begin
                        wdata_q <= rx_byte;
                        state   <= ST_WR_STROBE;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_RD_STROBE:  state <= ST_RD_CAPTURE;
                ST_RD_CAPTURE: begin
                    tx_q  <= io_rdata;
                    state <= ST_SEND;
                end
                ST_WR_STROBE:  state <= ST_IDLE;
                ST_SEND:       if (tx_ack) state <= ST_IDLE;
                default:       state <= ST_IDLE;
            endcase
        end
    end

    // Drive the port outputs from the registered phase.
    assign io_rd    = (state == ST_RD_STROBE);
    assign io_wr    = (state == ST_WR_STROBE);
    assign io_addr  = pend_addr;
    assign io_wdata = wdata_q;
    assign tx_req   = (state == ST_SEND);
    assign tx_byte  = tx_q;

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> !io_rd);                                       // R3
    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));                                      // R3
    AST_RD_THEN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |-> ##2 tx_req);                                   // R4
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ack) |=> (tx_req && $stable(tx_byte)));   // R4
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> !io_wr);                                       // R5
    AST_LOAD_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_ack) |=> !tx_req);                         // R10
endmodule

// File: tb/sim_dbg_exec.sv
// Bench: a cycle reference model compared on every clock, plus directed checks.
module sim_dbg_exec;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;
    localparam logic [15:0] MASK = 16'h00F3;

    logic clk = 0, rst_n = 0, rx_valid = 0, tx_ack = 0;
    logic [7:0] rx_byte = 0, io_rdata = 0, io_wdata, tx_byte;
    logic tx_req, io_rd, io_wr;
    logic [5:0] io_addr;
    logic [15:0] ptr_value;
    int checks = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_exec u0 (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack), .io_rd(io_rd),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .ptr_value(ptr_value));

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 5 + 1);
    endfunction

    // I/O target: registered read data, write on strobe.
    logic [7:0] mem [64];
    logic [7:0] mirror [64];
    initial for (int i = 0; i < 64; i++) begin mem[i] = init_val(i); mirror[i] = init_val(i); end
    always @(posedge clk) begin
        if (io_wr) mem[io_addr] <= io_wdata;
        if (io_rd) io_rdata <= mem[io_addr];
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference model: phase 0 idle, 1 awaiting data, 2/3 read, 4 write, 5 sending.
    int ph = 0, m_kind = 0, m_addr = 0;
    logic [7:0] m_csr [16];
    logic e_tx_req = 0, e_io_rd = 0, e_io_wr = 0;
    logic [7:0] e_tx_byte = 0, e_io_wdata = 0;
    logic [5:0] e_io_addr = 0;
    logic [15:0] e_ptr = 0;
    bit started = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; e_tx_req = 0; e_io_rd = 0; e_io_wr = 0; e_ptr = 0; started = 1;
            for (int i = 0; i < 16; i++) m_csr[i] = 0;
        end else begin
            e_io_rd = 0; e_io_wr = 0;
            case (ph)
                0: if (rx_valid) casez (rx_byte)
                    8'b0110100?: begin m_kind = 1; m_addr = rx_byte[0]; ph = 1; end
                    8'b0??1????: begin m_addr = {rx_byte[6:5], rx_byte[3:0]}; ph = 2;
                                       e_io_rd = 1; e_io_addr = 6'(m_addr); end
                    8'b1??1????: begin m_kind = 3; m_addr = {rx_byte[6:5], rx_byte[3:0]}; ph = 1; end
                    8'b1000????: begin e_tx_byte = m_csr[rx_byte[3:0]]; e_tx_req = 1; ph = 5; end
                    8'b1100????: begin m_kind = 5; m_addr = rx_byte[3:0]; ph = 1; end
                    default: ;
                endcase
                1: if (rx_valid) begin
                    if (m_kind == 1) begin
                        if (m_addr == 0) e_ptr[7:0] = rx_byte; else e_ptr[15:8] = rx_byte;
                        ph = 0;
                    end else if (m_kind == 3) begin
                        e_io_wr = 1; e_io_addr = 6'(m_addr); e_io_wdata = rx_byte;
                        mirror[m_addr] = rx_byte; ph = 4;
                    end else begin
                        if (MASK[m_addr]) m_csr[m_addr] = rx_byte;
                        ph = 0;
                    end
                end
                2: ph = 3;
                3: begin e_tx_byte = mirror[m_addr]; e_tx_req = 1; ph = 5; end
                4: ph = 0;
                default: if (tx_ack) begin e_tx_req = 0; ph = 0; end
            endcase
        end
    end

    // Per-cycle comparison, one time unit after each edge.
    always @(posedge clk) begin
        #1;
        if (started) begin
            chk("R2 ptr_value", ptr_value, e_ptr);
            chk("R3 io_rd", io_rd, e_io_rd);
            chk("R5 io_wr", io_wr, e_io_wr);
            chk("R4 tx_req", tx_req, e_tx_req);
            if (e_tx_req) chk("R4 tx_byte", tx_byte, e_tx_byte);
            if (e_io_rd || e_io_wr) chk("R3 io_addr", io_addr, e_io_addr);
            if (e_io_wr) chk("R5 io_wdata", io_wdata, e_io_wdata);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic send(logic [7:0] b);
        @(negedge clk); rx_valid = 1; rx_byte = b;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic take_tx(string req, logic [7:0] exp);
        for (int i = 0; i < 10 && !tx_req; i++) @(negedge clk);
        chk(req, tx_req, 1);
        chk(req, tx_byte, exp);
        tx_ack = 1; @(negedge clk); tx_ack = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 tx_req", tx_req, 0);
        chk("R1 io strobes", {io_rd, io_wr}, 0);
        chk("R1 ptr", ptr_value, 16'h0000);
        send(8'h84); take_tx("R1 csr zero", 8'h00);
        // R2: both pointer bytes
        send(8'h68); send(8'h34); send(8'h69); send(8'h12);
        chk("R2 ptr", ptr_value, 16'h1234);
        // R11: undecoded bytes ignored
        send(8'h6A); send(8'h6C); send(8'h00); send(8'hA0); send(8'hE5);
        repeat (3) @(negedge clk);
        chk("R11 ptr", ptr_value, 16'h1234);
        chk("R11 tx_req", tx_req, 0);
        // R7/R6: store then load
        send(8'hC1); send(8'h5A); send(8'h81); take_tx("R6 R7 csr1", 8'h5A);
        // R8: absent locations
        send(8'hC2); send(8'h77); send(8'h82); take_tx("R8 csr2", 8'h00);
        send(8'hC9); send(8'h11); send(8'h89); take_tx("R8 csr9", 8'h00);
        // R5 then R3/R4 readback through the same address 0x15
        send(8'hB5); send(8'hC3);
        repeat (2) @(negedge clk);
        chk("R5 mem", mem[21], 8'hC3);
        send(8'h35); take_tx("R3 R4 io read 0x15", 8'hC3);
        send(8'h7F); take_tx("R3 R4 io read 0x3F", init_val(63));
        // R9: data byte that looks like a load
        send(8'hC4); send(8'h81);
        chk("R9 no tx", tx_req, 0);
        send(8'h84); take_tx("R9 csr4", 8'h81);
        // R10: bytes during a pending load and during a read are dropped
        send(8'h81); send(8'hC5); send(8'h99); take_tx("R10 load", 8'h5A);
        send(8'h85); take_tx("R10 csr5", 8'h00);
        send(8'h35); send(8'hC6); send(8'h42); take_tx("R10 read", 8'hC3);
        send(8'h86); take_tx("R10 csr6", 8'h00);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule